// File: doc/BRIEF.md
# Stepped RSSI Gain Controller

This block is the digital half of a receiver's automatic gain control. Two comparator flags describe the received signal strength: one says the level is too low, the other says it is too high. The controller turns these flags into settings for three gain stages: a two-level second mixer, a two-level first mixer and a four-level LNA. The six reachable gain combinations form a single ladder. Going down the ladder, the second mixer is cut first, then the first mixer, then the LNA one step at a time. Going up, the same path is retraced in reverse.

A flag only counts after it has been seen on a programmable number of consecutive tuning-clock ticks. The tuning clock is given as a single-cycle enable, `tick`, in the system clock domain. The persistence delay can guard only gain increases, so that overload is answered at once. It can also guard both directions. When the controller is disabled, every stage sits at its highest gain.

Top module: `agc_stepper`

## Requirements
- R1: After reset, and for as long as `agc_en` is low, the outputs are `mix2_hi`=1, `mix1_hi`=1 and `lna_code`=3 whatever the flags do. Dropping `agc_en` returns these values on the next clock.
- R2: Each qualified high-flag event lowers the gain by one ladder step. From full gain the outputs pass through (m2,m1,lna) = (0,1,3), (0,0,3), (0,0,2), (0,0,1), (0,0,0). `lna_code` 3 is the default LNA gain; 2, 1 and 0 are the default less 2 dB, 6 dB and 20 dB.
- R3: Each qualified low-flag event raises the gain by one step, retracing the R2 path in reverse: the LNA first, then the first mixer, then the second mixer.
- R4: Every qualified event moves exactly one step. With no delay and a flag held on consecutive ticks, the gain moves one step per tick.
- R5: `delay_sel` values 0, 1, 2 and 3 select persistence delays of 0, 3, 15 and 31. For a delay D, a guarded flag takes effect on its (D+1)-th consecutive tick. Cycles without `tick` neither count nor change anything.
- R6: If a guarded flag is low on a tick before its delay is reached, its count restarts from zero.
- R7: With `delay_both`=0 only increases are delayed, and a high flag acts on its first tick. With `delay_both`=1 both directions are delayed.
- R8: At the lowest step, high-flag events leave the outputs unchanged. At the highest step, low-flag events leave the outputs unchanged.
- R9: When both flags are high on the same tick, the low flag is disregarded and the high flag is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle tuning-clock enable; flags are sampled only on it |
| agc_en | input | 1 | Enables gain control; low forces full gain |
| delay_sel | input | 2 | Persistence delay code (0, 3, 15, 31 ticks) |
| delay_both | input | 1 | 0: delay guards increases only; 1: both directions |
| rssi_lo | input | 1 | Signal-too-low flag (requests more gain) |
| rssi_hi | input | 1 | Signal-too-high flag (requests less gain) |
| mix2_hi | output | 1 | Second mixer gain: 1 = high (+9 dB), 0 = low (-2 dB) |
| mix1_hi | output | 1 | First mixer gain: 1 = high (+14 dB), 0 = low (0 dB) |
| lna_code | output | 2 | LNA gain code, 3 = default down to 0 = default less 20 dB |

## Verification
The ladder is walked down with an undelayed high flag held on successive ticks, and then back up with a delayed low flag. Together these show the exact stage order in each direction and that one event moves exactly one step. Flag trains one tick shorter than the delay, and trains broken by a single low tick, separate a correct persistence count from one that is off by one or that fails to restart. The same high-flag train is run in both delay modes to expose which directions the delay guards. Coincident flags, pushes past either end of the ladder, long delay codes and flags held without ticks cover the remaining corners.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // Direction index for the two persistence qualifiers
  localparam int DIR_DN = 0;
  localparam int DIR_UP = 1;
  localparam int NUM_DIR = 2;

  typedef enum logic [1:0] {
    DLY_ZERO  = 2'd0,
    DLY_SHORT = 2'd1,
    DLY_MID   = 2'd2,
    DLY_LONG  = 2'd3
  } delay_code_e;
endpackage

// File: rtl/agc_persist.sv
module agc_persist #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             flag,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;

  // >= keeps a shortened limit from stranding a running count
  assign fire = tick && flag && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (!flag || fire) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !flag && !clr) |=> (cnt == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/agc_ladder.sv
module agc_ladder #(
  parameter int LNA_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step_dn,
  input  logic             step_up,
  output logic             mix2_hi,
  output logic             mix1_hi,
  output logic [LNA_W-1:0] lna_code
);
  localparam int LNA_TOP   = (1 << LNA_W) - 1;
  localparam int MAX_LEVEL = LNA_TOP + 2;
  localparam int LVL_W     = $clog2(MAX_LEVEL + 1);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(MAX_LEVEL);
  localparam logic [LVL_W-1:0] LVL_M1  = LVL_W'(MAX_LEVEL - 1);
  localparam logic [LVL_W-1:0] LVL_LNA = LVL_W'(LNA_TOP);

  logic [LVL_W-1:0] level, level_nx;

  always_comb begin
    level_nx = level;
    if (!en) begin
      level_nx = LVL_MAX;
    end else if (step_dn) begin
      if (level != '0) level_nx = level - 1'b1;
    end else if (step_up) begin
      if (level != LVL_MAX) level_nx = level + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= LVL_MAX;
      mix2_hi  <= 1'b1;
      mix1_hi  <= 1'b1;
      lna_code <= '1;
    end else begin
      level    <= level_nx;
      mix2_hi  <= (level_nx == LVL_MAX);
      mix1_hi  <= (level_nx >= LVL_M1);
      lna_code <= (level_nx >= LVL_LNA) ? LNA_W'(LNA_TOP) : level_nx[LNA_W-1:0];
    end
  end

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (level == $past(level) || level == $past(level) + 1'b1 ||
            level + 1'b1 == $past(level)));

  // R1
  idle_full_gain_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (mix2_hi && mix1_hi && lna_code == '1));

  // R2
  mixer_order_chk: assert property (@(posedge clk) disable iff (rst)
    !mix1_hi |-> !mix2_hi);

  // R3
  lna_order_chk: assert property (@(posedge clk) disable iff (rst)
    (lna_code != '1) |-> !mix1_hi);

  // R8
  floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && level == '0 && !step_up) |=> (level == '0));
endmodule

// File: rtl/agc_stepper.sv
module agc_stepper #(
  parameter int DLY_SHORT_N = 3,
  parameter int DLY_MID_N   = 15,
  parameter int DLY_LONG_N  = 31,
  parameter int LNA_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             agc_en,
  input  logic [1:0]       delay_sel,
  input  logic             delay_both,
  input  logic             rssi_lo,
  input  logic             rssi_hi,
  output logic             mix2_hi,
  output logic             mix1_hi,
  output logic [LNA_W-1:0] lna_code
);
  import agc_pkg::*;

  localparam int CNT_W = $clog2(DLY_LONG_N + 1);

  logic [CNT_W-1:0]   sel_limit;
  logic [NUM_DIR-1:0] req_flag;
  logic [NUM_DIR-1:0] req_fire;
  logic [CNT_W-1:0]   req_limit [NUM_DIR];

  always_comb begin
    case (delay_code_e'(delay_sel))
      DLY_SHORT: sel_limit = CNT_W'(DLY_SHORT_N);
      DLY_MID:   sel_limit = CNT_W'(DLY_MID_N);
      DLY_LONG:  sel_limit = CNT_W'(DLY_LONG_N);
      default:   sel_limit = '0;
    endcase
  end

  // High flag has priority; a coincident low flag is treated as absent
  assign req_flag[DIR_DN]  = rssi_hi;
  assign req_flag[DIR_UP]  = rssi_lo && !rssi_hi;
  assign req_limit[DIR_DN] = delay_both ? sel_limit : '0;
  assign req_limit[DIR_UP] = sel_limit;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    agc_persist #(.CNT_W(CNT_W)) u_persist (
      .clk   (clk),
      .rst   (rst),
      .clr   (!agc_en),
      .tick  (tick),
      .flag  (req_flag[g]),
      .limit (req_limit[g]),
      .fire  (req_fire[g])
    );
  end

  agc_ladder #(.LNA_W(LNA_W)) u_ladder (
    .clk      (clk),
    .rst      (rst),
    .en       (agc_en),
    .step_dn  (req_fire[DIR_DN]),
    .step_up  (req_fire[DIR_UP]),
    .mix2_hi  (mix2_hi),
    .mix1_hi  (mix1_hi),
    .lna_code (lna_code)
  );

  // R9
  hi_wins_chk: assert property (@(posedge clk) disable iff (rst)
    rssi_hi |-> !req_fire[DIR_UP]);

  // R7
  fast_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (agc_en && tick && rssi_hi && !delay_both) |-> req_fire[DIR_DN]);
endmodule

// File: tb/agc_stepper_bench.sv
module agc_stepper_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       agc_en = 1'b0;
  logic [1:0] delay_sel = 2'd0;
  logic       delay_both = 1'b0;
  logic       rssi_lo = 1'b0;
  logic       rssi_hi = 1'b0;
  logic       mix2_hi, mix1_hi;
  logic [1:0] lna_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  agc_stepper u_agc_stepper (
    .clk(clk), .rst(rst), .tick(tick), .agc_en(agc_en),
    .delay_sel(delay_sel), .delay_both(delay_both),
    .rssi_lo(rssi_lo), .rssi_hi(rssi_hi),
    .mix2_hi(mix2_hi), .mix1_hi(mix1_hi), .lna_code(lna_code)
  );

  // Ladder step 5 = full gain ... 0 = lowest, per R2
  function automatic logic [3:0] expect_of(input int lvl);
    logic [1:0] l;
    l = (lvl >= 3) ? 2'd3 : 2'(lvl);
    return {(lvl == 5), (lvl >= 4), l};
  endfunction

  task automatic check(input int lvl, input string tag);
    logic [3:0] exp_v, act_v;
    exp_v = expect_of(lvl);
    act_v = {mix2_hi, mix1_hi, lna_code};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: got m2/m1/lna=%b expected %b (step %0d)", tag, act_v, exp_v, lvl);
    end
  endtask

  task automatic pulse(input logic hi, input logic lo);
    @(negedge clk);
    rssi_hi = hi; rssi_lo = lo; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; rssi_hi = 1'b0; rssi_lo = 1'b0;
  endtask

  task automatic pulses(input int n, input logic hi, input logic lo);
    for (int i = 0; i < n; i++) pulse(hi, lo);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(5, "R1 reset");
    pulses(3, 1'b1, 1'b0);
    check(5, "R1 disabled ignores high flag");
  endtask

  task automatic t_down_order;
    agc_en = 1'b1; delay_sel = 2'd0; delay_both = 1'b0;
    @(negedge clk);
    for (int lvl = 4; lvl >= 0; lvl--) begin
      pulse(1'b1, 1'b0);
      check(lvl, "R2 R4 down step");
    end
    pulses(2, 1'b1, 1'b0);
    check(0, "R8 floor");
  endtask

  task automatic t_up_delay;
    delay_sel = 2'd1;
    for (int lvl = 1; lvl <= 5; lvl++) begin
      pulses(3, 1'b0, 1'b1);
      check(lvl - 1, "R5 delay 3 not yet");
      pulse(1'b0, 1'b1);
      check(lvl, "R3 up step");
    end
    pulses(4, 1'b0, 1'b1);
    check(5, "R8 ceiling");
    @(negedge clk);
    rssi_hi = 1'b1;
    repeat (10) @(negedge clk);
    rssi_hi = 1'b0;
    check(5, "R5 no tick no count");
  endtask

  task automatic t_asym;
    delay_sel = 2'd1; delay_both = 1'b0;
    pulse(1'b1, 1'b0);
    check(4, "R7 increase-only mode cuts at once");
    delay_both = 1'b1;
    pulses(3, 1'b1, 1'b0);
    check(4, "R7 both mode holds cut");
    pulse(1'b1, 1'b0);
    check(3, "R7 both mode cuts on 4th");
  endtask

  task automatic t_restart;
    pulses(3, 1'b1, 1'b0);
    pulse(1'b0, 1'b0);
    pulses(3, 1'b1, 1'b0);
    check(3, "R6 restart after gap");
    pulse(1'b1, 1'b0);
    check(2, "R6 fires after full run");
  endtask

  task automatic t_both_flags;
    delay_sel = 2'd0; delay_both = 1'b0;
    pulse(1'b1, 1'b1);
    check(1, "R9 high wins");
  endtask

  task automatic t_long;
    @(negedge clk); agc_en = 1'b0;
    @(negedge clk);
    check(5, "R1 disable restores");
    agc_en = 1'b1; delay_sel = 2'd2; delay_both = 1'b1;
    pulses(15, 1'b1, 1'b0);
    check(5, "R5 delay 15 not yet");
    pulse(1'b1, 1'b0);
    check(4, "R5 delay 15 fires");
    delay_sel = 2'd3;
    pulses(31, 1'b1, 1'b0);
    check(4, "R5 delay 31 not yet");
    pulse(1'b1, 1'b0);
    check(3, "R5 delay 31 fires");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_down_order();
    t_up_delay();
    t_asym();
    t_restart();
    t_both_flags();
    t_long();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule